// File: doc/BRIEF.md
# Two-Bank DRAM Controller

This block connects a 16-bit processor bus to two banks of external DRAM. Each bus request carries a word address, a read/write flag and two byte-lane enables. It is compared against a window register for each bank. A request that hits a window runs a fixed access sequence. The controller first drives the row half of the address while that bank's row strobe goes low. It then switches the shared address lines to the column half and lowers the column strobes of the enabled byte lanes. In that same clock it returns a one-cycle acknowledge, so the requester never sees added wait states. Writes also hold a dedicated DRAM write strobe low for the length of the access.

A programmable countdown timer raises refresh requests. Each refresh is a CAS-before-RAS cycle that covers both banks. The sequencer arbitrates refresh against bus accesses: an access that has already started always finishes first, and no new access is taken while a refresh is pending or running. Requests enter through a valid/ready handshake. `req_ready` is high only while the sequencer is idle and no refresh is waiting. A requester that sees `req_ready` low must hold `req_valid` and the request fields unchanged until the request is taken. The acknowledge and the DRAM pins are plain outputs without back-pressure.

Top module: `dram_bank_ctrl`

## Requirements
- R1: While reset is applied and after it is released, all row and column strobes are high, `dram_we_n` is high and `bus_ack` is low. Both banks start disabled, the refresh interval is 0 and the hold field is 0.
- R2: The register port writes on `cfg_we`. Address 0 is bank 0's window and address 1 is bank 1's window: bits [7:0] give the match value for request byte-address bits [23:16], and bits [15:8] give a mask in which 1 means the bit is compared. Address 2 is the refresh interval. Address 3 is control: bit 0 enables bank 0, bit 1 enables bank 1, and bits [5:2] are the refresh hold. An enabled bank hits when all of its masked bits match. When both banks hit, bank 0 is used.
- R3: A request that hits no enabled bank is accepted and then ignored: no strobe moves and no acknowledge is given.
- R4: For a hit taken at clock edge T, the cycle after T has the bank's row strobe low (ras_n bit b for bank b) and `dram_addr` equal to byte-address bits [16:9]. The next cycle has `dram_addr` equal to bits [8:1] with the column strobes still high. The cycle after that has the column strobes low and `bus_ack` high for exactly one cycle. After that cycle all strobes are high again.
- R5: `req_be[1]` selects the upper byte (D15–D8) and drives `cas_n[0]`. `req_be[0]` selects the lower byte (D7–D0) and drives `cas_n[1]`.
- R6: `dram_we_n` is low from the row-strobe cycle through the acknowledge cycle of a write, and it stays high for reads.
- R7: `req_ready` is high only when the sequencer is idle and no refresh is pending. The request fields are captured on the accepting edge.
- R8: When the refresh interval P is nonzero, the timer reloads with P on every refresh request, so refreshes start every P cycles while the bus is otherwise idle. When P is 0, no refresh occurs.
- R9: A refresh first lowers both column strobes for one cycle while the row strobes stay high. It then holds both row strobes and both column strobes low for H cycles, where H is the hold field and a value of 0 counts as 1. After that all strobes rise together.
- R10: A pending refresh waits until the running access has ended. A request made during a refresh is accepted in the first cycle after the refresh ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 23 | Word address (byte-address bits 23..1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| bus_ack | output | 1 | One-cycle transfer acknowledge |
| dram_addr | output | 8 | Multiplexed row/column address |
| ras_n | output | 2 | Row strobes, one per bank, active low |
| cas_n | output | 2 | Column strobes, one per byte lane, active low |
| dram_we_n | output | 1 | DRAM write strobe, active low |

## Verification
The assertions assume that the requester honours the handshake. A request that is held waiting keeps its fields unchanged, and no sequence checks follow a request that is withdrawn. The bench drives each request on a falling edge and holds it until `req_ready` is seen high, so this assumption is always met. The bench writes registers only between its own accesses. Random addresses are drawn from byte ranges chosen to fall inside or outside the programmed windows. The timer phase during the random run with refresh enabled is left free, so refresh requests land at every point of an access.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_CAS, ST_RCAS, ST_RHOLD
  } seq_state_t;

  localparam logic [1:0] CFG_WIN0 = 2'd0;
  localparam logic [1:0] CFG_WIN1 = 2'd1;
  localparam logic [1:0] CFG_RPER = 2'd2;
  localparam logic [1:0] CFG_CTRL = 2'd3;

  localparam int LANES = 2;
endpackage

// File: rtl/dramc_regs.sv
module dramc_regs import dramc_pkg::*; #(
  parameter int NBANK = 2,
  parameter int MW    = 8,
  parameter int CFG_W = 16,
  parameter int HW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_addr,
  input  logic [CFG_W-1:0]          cfg_wdata,
  output logic [NBANK-1:0][MW-1:0]  win_base,
  output logic [NBANK-1:0][MW-1:0]  win_mask,
  output logic [NBANK-1:0]          bank_en,
  output logic [CFG_W-1:0]          ref_period,
  output logic [HW-1:0]             ref_hold
);
  for (genvar b = 0; b < NBANK; b++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_base[b] <= '0;
        win_mask[b] <= '0;
      end else if (cfg_we && cfg_addr == 2'(b)) begin
        win_base[b] <= cfg_wdata[MW-1:0];
        win_mask[b] <= cfg_wdata[2*MW-1:MW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_en    <= '0;
      ref_period <= '0;
      ref_hold   <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_RPER) ref_period <= cfg_wdata;
      if (cfg_addr == CFG_CTRL) begin
        bank_en  <= cfg_wdata[NBANK-1:0];
        ref_hold <= cfg_wdata[NBANK+HW-1:NBANK];
      end
    end
  end
endmodule

// File: rtl/dramc_decode.sv
module dramc_decode #(
  parameter int NBANK = 2,
  parameter int MW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MW-1:0]            addr_top,
  input  logic [NBANK-1:0][MW-1:0] win_base,
  input  logic [NBANK-1:0][MW-1:0] win_mask,
  input  logic [NBANK-1:0]         bank_en,
  output logic [NBANK-1:0]         hit_sel
);
  logic [NBANK-1:0] hit_raw;

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    assign hit_raw[b] = bank_en[b] && (((addr_top ^ win_base[b]) & win_mask[b]) == '0);
  end

  // lowest-numbered bank wins
  assign hit_sel = hit_raw & (~hit_raw + NBANK'(1));

  assert_single_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_sel) && ((hit_sel & ~bank_en) == '0));
endmodule

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (period == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= period;
      tick <= 1'b0;
    end else if (cnt == PER_W'(1)) begin
      cnt  <= period;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - PER_W'(1);
      tick <= 1'b0;
    end
  end

  assert_off_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> !tick);
  assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != PER_W'(1)) |=> !tick);
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq import dramc_pkg::*; #(
  parameter int NBANK = 2,
  parameter int MUX_W = 8,
  parameter int HW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [MUX_W-1:0] req_row,
  input  logic [MUX_W-1:0] req_col,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic [NBANK-1:0] hit_sel,
  input  logic             ref_tick,
  input  logic [HW-1:0]    ref_hold,
  output logic             bus_ack,
  output logic [MUX_W-1:0] dram_addr,
  output logic [NBANK-1:0] ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             dram_we_n
);
  seq_state_t       state;
  logic [NBANK-1:0] bank_q;
  logic [MUX_W-1:0] row_q, col_q;
  logic [LANES-1:0] be_q;
  logic             wr_q, ref_pend;
  logic [HW-1:0]    hcnt;
  logic             accept, in_access, in_refresh;
  logic [LANES-1:0] cas_act;

  assign req_ready  = (state == ST_IDLE) && !ref_pend;
  assign accept     = req_valid && req_ready;
  assign in_access  = (state == ST_ROW) || (state == ST_COL) || (state == ST_CAS);
  assign in_refresh = (state == ST_RCAS) || (state == ST_RHOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bank_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      be_q     <= '0;
      wr_q     <= 1'b0;
      ref_pend <= 1'b0;
      hcnt     <= '0;
    end else begin
      ref_pend <= ref_tick || (ref_pend && state != ST_IDLE);
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state <= ST_RCAS;
          end else if (accept && hit_sel != '0) begin
            state  <= ST_ROW;
            bank_q <= hit_sel;
            row_q  <= req_row;
            col_q  <= req_col;
            be_q   <= req_be;
            wr_q   <= req_write;
          end
        end
        ST_ROW:  state <= ST_COL;
        ST_COL:  state <= ST_CAS;
        ST_CAS:  state <= ST_IDLE;
        ST_RCAS: begin
          state <= ST_RHOLD;
          hcnt  <= (ref_hold == '0) ? HW'(1) : ref_hold;
        end
        ST_RHOLD: begin
          if (hcnt <= HW'(1)) state <= ST_IDLE;
          else                hcnt  <= hcnt - HW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // lane 0 carries the upper byte, lane 1 the lower byte
  always_comb begin
    cas_act = '0;
    if (state == ST_CAS)  cas_act = {be_q[0], be_q[1]};
    else if (in_refresh)  cas_act = '1;
  end

  assign cas_n     = ~cas_act;
  assign ras_n     = ~(in_access ? bank_q : ((state == ST_RHOLD) ? {NBANK{1'b1}} : '0));
  assign dram_we_n = ~(in_access && wr_q);
  assign bus_ack   = (state == ST_CAS);
  assign dram_addr = ((state == ST_COL) || (state == ST_CAS)) ? col_q : row_q;

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  assert_row_before_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (ras_n != '1) && ($past(ras_n) == ras_n) && ($past(cas_n) == '1));
  assert_cas_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n == '0) && ($past(ras_n) != '0)) |-> ($past(cas_n) == '0));
  assert_refresh_all_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) |-> (cas_n == '0) && dram_we_n && !bus_ack);
  assert_no_take_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_refresh || in_access) |-> !req_ready);
  assert_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (ras_n != '1) && (ras_n != '0));
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl import dramc_pkg::*; #(
  parameter int NBANK = 2,
  parameter int AW    = 24,
  parameter int MUX_W = 8,
  parameter int MW    = 8,
  parameter int CFG_W = 16,
  parameter int HW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:1]    req_addr,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  output logic             bus_ack,
  output logic [MUX_W-1:0] dram_addr,
  output logic [NBANK-1:0] ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             dram_we_n
);
  localparam int COL_LO = 1;
  localparam int ROW_LO = COL_LO + MUX_W;

  logic [NBANK-1:0][MW-1:0] win_base, win_mask;
  logic [NBANK-1:0]         bank_en, hit_sel;
  logic [CFG_W-1:0]         ref_period;
  logic [HW-1:0]            ref_hold;
  logic                     ref_tick;

  dramc_regs #(.NBANK(NBANK), .MW(MW), .CFG_W(CFG_W), .HW(HW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_base(win_base), .win_mask(win_mask),
    .bank_en(bank_en), .ref_period(ref_period), .ref_hold(ref_hold));

  dramc_decode #(.NBANK(NBANK), .MW(MW)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr_top(req_addr[AW-1 -: MW]),
    .win_base(win_base), .win_mask(win_mask), .bank_en(bank_en),
    .hit_sel(hit_sel));

  dramc_refresh_timer #(.PER_W(CFG_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .period(ref_period), .tick(ref_tick));

  dramc_seq #(.NBANK(NBANK), .MUX_W(MUX_W), .HW(HW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_addr[ROW_LO +: MUX_W]), .req_col(req_addr[COL_LO +: MUX_W]),
    .req_write(req_write), .req_be(req_be), .hit_sel(hit_sel),
    .ref_tick(ref_tick), .ref_hold(ref_hold), .bus_ack(bus_ack),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .dram_we_n(dram_we_n));
endmodule

// File: tb/dram_bank_ctrl_test.sv
`timescale 1ns/1ps
module dram_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:1] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = '0;
  logic        bus_ack;
  logic [7:0]  dram_addr;
  logic [1:0]  ras_n, cas_n;
  logic        dram_we_n;

  int total = 0, failed = 0;
  bit done = 0;
  logic [7:0] m_base [2];
  logic [7:0] m_mask [2];
  logic [1:0] m_en = 2'b00;

  always #5 clk = ~clk;

  dram_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .bus_ack(bus_ack), .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
    .dram_we_n(dram_we_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_bank(input logic [23:0] a);
    for (int b = 0; b < 2; b++)
      if (m_en[b] && (((a[23:16] ^ m_base[b]) & m_mask[b]) == 8'h00))
        return 2'(1 << b);
    return 2'b00;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: begin m_base[0] = d[7:0]; m_mask[0] = d[15:8]; end
      2'd1: begin m_base[1] = d[7:0]; m_mask[1] = d[15:8]; end
      2'd3: m_en = d[1:0];
      default: ;
    endcase
  endtask

  task automatic do_access(input logic [23:0] a, input bit wr,
                           input logic [1:0] be, output int waited);
    logic [1:0] eb;
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[23:1]; req_write = wr; req_be = be;
    while (!req_ready) begin @(negedge clk); waited++; end
    @(negedge clk);
    req_valid = 1'b0;
    eb = exp_bank(a);
    if (eb == 2'b00) begin
      for (int i = 0; i < 3; i++) begin
        chk(ras_n == 2'b11 && cas_n == 2'b11 && !bus_ack, "R3", "miss strobes",
            {bus_ack, cas_n, ras_n}, 5'b01111);
        @(negedge clk);
      end
    end else begin
      chk(ras_n == ~eb, "R2", "row strobe bank", ras_n, ~eb);
      chk(dram_addr == a[16:9] && cas_n == 2'b11 && !bus_ack, "R4", "row phase",
          {bus_ack, cas_n, dram_addr}, {3'b011, a[16:9]});
      chk(dram_we_n == !wr, "R6", "we in row", dram_we_n, !wr);
      @(negedge clk);
      chk(dram_addr == a[8:1] && cas_n == 2'b11 && ras_n == ~eb, "R4", "column phase",
          {ras_n, cas_n, dram_addr}, {~eb, 2'b11, a[8:1]});
      @(negedge clk);
      chk(cas_n == ~{be[0], be[1]}, "R5", "lane strobes", cas_n, ~{be[0], be[1]});
      chk(bus_ack && ras_n == ~eb && dram_addr == a[8:1], "R4", "ack cycle",
          {bus_ack, ras_n}, {1'b1, ~eb});
      chk(dram_we_n == !wr, "R6", "we in cas", dram_we_n, !wr);
      @(negedge clk);
      chk(!bus_ack && ras_n == 2'b11 && dram_we_n, "R4", "end of access",
          {bus_ack, ras_n, dram_we_n}, 4'b0111);
    end
  endtask

  task automatic wait_ref_start(output int cyc);
    cyc = 0;
    while (!(cas_n == 2'b00 && ras_n == 2'b11) && cyc < 2000) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic check_refresh(input int h);
    int c;
    wait_ref_start(c);
    chk(c < 2000, "R8", "refresh seen", c, 0);
    chk(!req_ready, "R10", "ready during refresh", req_ready, 0);
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      chk(ras_n == 2'b00 && cas_n == 2'b00, "R9", "hold cycle", {ras_n, cas_n}, 0);
    end
    @(negedge clk);
    chk(ras_n == 2'b11 && cas_n == 2'b11, "R9", "release", {ras_n, cas_n}, 4'hf);
  endtask

  function automatic logic [23:0] rand_addr(input int kind);
    logic [23:0] r = 24'($urandom);
    case (kind)
      0: return {4'h1, r[19:0]};
      1: return {8'h40, r[15:0]};
      default: return {2'b10, r[21:0]};
    endcase
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int w, c, kind;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(ras_n == 2'b11 && cas_n == 2'b11 && dram_we_n && !bus_ack, "R1", "in reset",
        {ras_n, cas_n, dram_we_n, bus_ack}, 6'b111110);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(ras_n == 2'b11 && cas_n == 2'b11 && dram_we_n && !bus_ack && req_ready, "R1",
        "after reset", {ras_n, cas_n, dram_we_n, bus_ack}, 6'b111110);
    m_base[0] = 0; m_mask[0] = 0; m_base[1] = 0; m_mask[1] = 0;
    do_access(24'h12_3456, 1'b0, 2'b11, w);

    cfg_write(2'd0, 16'hF0_12);
    cfg_write(2'd1, 16'hFF_40);
    cfg_write(2'd3, 16'h0003);
    chk(req_ready, "R7", "ready idle", req_ready, 1);
    do_access(24'h13_A5C2, 1'b0, 2'b11, w);
    do_access(24'h40_0102, 1'b1, 2'b10, w);
    do_access(24'h40_FFFE, 1'b1, 2'b01, w);
    cfg_write(2'd1, 16'h00_00);
    do_access(24'h1F_0010, 1'b0, 2'b11, w);
    do_access(24'h77_0010, 1'b1, 2'b11, w);
    cfg_write(2'd1, 16'hFF_40);
    cfg_write(2'd3, 16'h0001);
    do_access(24'h40_1234, 1'b1, 2'b11, w);
    cfg_write(2'd3, 16'h0003);

    for (int i = 0; i < 40; i++) begin
      kind = $urandom_range(0, 2);
      do_access(rand_addr(kind), 1'($urandom), 2'($urandom_range(1, 3)), w);
    end

    c = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cas_n != 2'b11) c++;
    end
    chk(c == 0, "R8", "interval 0 idle", c, 0);

    cfg_write(2'd3, 16'h0003);
    cfg_write(2'd2, 16'd30);
    check_refresh(1);
    cfg_write(2'd3, 16'h000F);
    cfg_write(2'd2, 16'd20);
    check_refresh(3);
    wait_ref_start(c);
    check_refresh(3);
    wait_ref_start(c);
    chk(c + 4 == 20, "R8", "refresh interval", c + 4, 20);

    cfg_write(2'd2, 16'd200);
    wait_ref_start(c);
    do_access(24'h15_0F0E, 1'b1, 2'b11, w);
    chk(w == 3, "R10", "held access wait", w, 3);

    cfg_write(2'd3, 16'h000B);
    cfg_write(2'd2, 16'd13);
    for (int i = 0; i < 60; i++) begin
      kind = $urandom_range(0, 1);
      do_access(rand_addr(kind), 1'($urandom), 2'($urandom_range(1, 3)), w);
    end
    check_refresh(2);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule